// File: doc/BRIEF.md
# Register Rename Stage with Physical Register Free Pool

This block renames a group of instructions every cycle for an out-of-order core. Each lane carries two logical source registers and one logical destination. Sources are translated through a speculative map table, which holds one physical register id per logical register. Each lane that writes a destination takes a fresh physical register from a free pool. When a source names a register written by an earlier lane of the same group, it takes that lane's new physical register rather than the table entry. For every destination the block also returns the physical register that held the logical register before, so the retirement logic can hand it back once the instruction commits.

A commit port gives back that older register and updates a committed copy of the map. A checkpoint port copies the speculative map into one of several shadow slots. The restore port has two modes. In snapshot mode, it reloads the speculative map from a slot and returns every register allocated since that slot was taken. In committed mode, it reloads the speculative map from the committed map and rebuilds the pool as every register the committed map does not use.

Top module: `rn_rename_top`

## Requirements
- R1: After reset, logical register i maps to physical register i, physical registers NLOG to NPHYS-1 are free, and the first register granted is NLOG (6 by default).
- R2: Each writing lane of a renamed group gets a distinct free register. Writing lanes are served in lane order from the lowest-numbered free register upward. A granted register leaves the pool.
- R3: A lane's physical source equals the speculative map entry for that logical source. If an earlier lane in the same group writes that logical register, the source instead takes the new register of the latest such lane.
- R4: A writing lane's previous-mapping output is the speculative map entry for its destination. If an earlier lane in the group writes the same logical register, it is instead that lane's new register. The map keeps the last lane's register.
- R5: The request is not accepted (ready low) when the pool holds fewer registers than the number of lanes with both valid and write set. An unaccepted request changes neither the map nor the pool.
- R6: A commit returns its previous-mapping register to the pool, where it can be granted again from the next cycle. It also sets the committed map entry of its logical register to its new register.
- R7: A checkpoint taken in a cycle captures the speculative map including the group renamed in that same cycle.
- R8: A snapshot-mode restore loads the speculative map from the chosen slot and returns every register granted after that checkpoint to the pool. Ready is low in the restore cycle.
- R9: A committed-mode restore loads the speculative map from the committed map and makes exactly the registers absent from the committed map free.
- R10: A valid lane with its write flag clear takes no register and leaves the map unchanged. A group of such lanes is accepted even when the pool is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ren_valid | input | 1 | Rename group presented |
| ren_lane_vld | input | LANES | Per-lane instruction valid |
| ren_src1 | input | LANES*LW | First logical source per lane (lane k at bits k*LW) |
| ren_src2 | input | LANES*LW | Second logical source per lane |
| ren_dst | input | LANES*LW | Logical destination per lane |
| ren_wr | input | LANES | Lane writes its destination |
| ren_ready | output | 1 | Group accepted this cycle when ren_valid is high |
| ren_psrc1 | output | LANES*PW | Physical first source per lane |
| ren_psrc2 | output | LANES*PW | Physical second source per lane |
| ren_pdst | output | LANES*PW | New physical destination per lane |
| ren_pold | output | LANES*PW | Previous physical mapping of the destination |
| cmt_valid | input | 1 | An instruction with a destination commits |
| cmt_ldst | input | LW | Its logical destination |
| cmt_pnew | input | PW | Its new physical register |
| cmt_pold | input | PW | Its previous physical register, to be freed |
| ck_take | input | 1 | Take a checkpoint |
| ck_slot | input | CW | Slot written by the checkpoint |
| rs_valid | input | 1 | Restore the speculative state |
| rs_full | input | 1 | 1: restore from committed map; 0: restore from a slot |
| rs_slot | input | CW | Slot used by a snapshot restore |

## Verification
The bench targets same-group steering when two lanes write the same logical register. A design that read only the table would hand the second lane a stale source and a wrong previous mapping, and that register would later be freed while still live. It drains the pool to one and then zero entries and presents two-writer and no-writer groups. A design counting the wrong lanes would either over-allocate or stall a group that needs no registers. It checks that a checkpoint taken alongside a rename contains that group, and that the registers granted after it come back in the expected order after restore. Finally, it flushes to the committed map and checks that the pool is rebuilt so that the lowest register not in the committed map is granted next. A design that kept stale free bits would hand out a register that is still mapped.

// File: rtl/rn_pkg.sv
// Shared types for the rename stage.
// Assumes: only the restore selector needs a named encoding.
package rn_pkg;
    typedef enum logic [1:0] {
        RST_NONE      = 2'd0,
        RST_SNAP      = 2'd1,
        RST_COMMITTED = 2'd2
    } restore_e;
endpackage

// File: rtl/rn_freelist.sv
// Free pool of physical registers kept as a bitmap.
// Grants the lowest free ids to requesting lanes in lane order, reports whether
// enough are free for the whole group, and accepts releases, a merge mask
// (snapshot restore) and a full reload (committed restore).
// Assumes: releases never name a register that is already free.
module rn_freelist #(
    parameter int NPHYS = 10,
    parameter int NLOG  = 6,
    parameter int LANES = 2,
    localparam int PW   = $clog2(NPHYS),
    localparam int CNTW = $clog2(((NPHYS > LANES) ? NPHYS : LANES) + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [LANES-1:0]            want,
    input  logic                        take_en,
    input  logic                        rel_en,
    input  logic [PW-1:0]               rel_id,
    input  logic                        merge_en,
    input  logic [NPHYS-1:0]            merge_mask,
    input  logic                        load_en,
    input  logic [NPHYS-1:0]            load_mask,
    output logic [LANES-1:0][PW-1:0]    grant,
    output logic [NPHYS-1:0]            alloc_mask,
    output logic                        enough,
    output logic [NPHYS-1:0]            pool
);
    logic [NPHYS-1:0] pool_q;
    logic [NPHYS-1:0] rel_mask;
    logic [CNTW-1:0]  n_free;
    logic [CNTW-1:0]  n_need;

    assign pool     = pool_q;
    assign rel_mask = rel_en ? (NPHYS'(1) << rel_id) : '0;

    // Pick the lowest remaining free id for each requesting lane in order.
    always_comb begin : pick
        logic [NPHYS-1:0] left;
        logic             hit;
        left       = pool_q;
        alloc_mask = '0;
        for (int k = 0; k < LANES; k++) begin
            grant[k] = '0;
            hit      = 1'b0;
            for (int p = 0; p < NPHYS; p++) begin
                if (want[k] && !hit && left[p]) begin
                    grant[k]      = PW'(p);
                    hit           = 1'b1;
                    left[p]       = 1'b0;
                    alloc_mask[p] = 1'b1;
                end
            end
        end
    end

    // Count free entries and requested entries to decide whether the group fits.
    always_comb begin
        n_free = '0;
        n_need = '0;
        for (int p = 0; p < NPHYS; p++) n_free = n_free + CNTW'(pool_q[p]);
        for (int k = 0; k < LANES; k++) n_need = n_need + CNTW'(want[k]);
        enough = (n_free >= n_need);
    end

    // Pool update: reload wins, else clear granted, set released and merged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NPHYS; p++) pool_q[p] <= (p >= NLOG);
        end else if (load_en) begin
            pool_q <= load_mask;
        end else begin
            pool_q <= (pool_q & ~(take_en ? alloc_mask : '0))
                    | rel_mask
                    | (merge_en ? merge_mask : '0);
        end
    end
endmodule

// File: rtl/rn_resolve.sv
// Same-group dependence resolution, purely combinational.
// Produces physical sources and previous mappings per lane, steering from the
// latest earlier writer in the group, and the map as it stands after the group.
// Assumes: lane 0 is oldest; grants are valid for lanes that write.
module rn_resolve #(
    parameter int NLOG  = 6,
    parameter int NPHYS = 10,
    parameter int LANES = 2,
    localparam int LW   = $clog2(NLOG),
    localparam int PW   = $clog2(NPHYS)
) (
    input  logic [NLOG-1:0][PW-1:0]   map_cur,
    input  logic [LANES-1:0]          lane_wr,
    input  logic [LANES-1:0][LW-1:0]  src1,
    input  logic [LANES-1:0][LW-1:0]  src2,
    input  logic [LANES-1:0][LW-1:0]  dst,
    input  logic [LANES-1:0][PW-1:0]  pnew,
    output logic [LANES-1:0][PW-1:0]  psrc1,
    output logic [LANES-1:0][PW-1:0]  psrc2,
    output logic [LANES-1:0][PW-1:0]  pold,
    output logic [NLOG-1:0][PW-1:0]   map_next
);
    // Look up each lane, then override with any earlier writer; later lanes win.
    always_comb begin
        for (int j = 0; j < LANES; j++) begin
            psrc1[j] = map_cur[src1[j]];
            psrc2[j] = map_cur[src2[j]];
            pold[j]  = map_cur[dst[j]];
            for (int i = 0; i < j; i++) begin
                if (lane_wr[i] && dst[i] == src1[j]) psrc1[j] = pnew[i];
                if (lane_wr[i] && dst[i] == src2[j]) psrc2[j] = pnew[i];
                if (lane_wr[i] && dst[i] == dst[j])  pold[j]  = pnew[i];
            end
        end
    end

    // Apply the group's writes in lane order to form the next map.
    always_comb begin
        map_next = map_cur;
        for (int i = 0; i < LANES; i++) begin
            if (lane_wr[i]) map_next[dst[i]] = pnew[i];
        end
    end
endmodule

// File: rtl/rn_ckpt.sv
// Shadow slots of the speculative map, each with a mask of registers granted
// since the slot was written.
// Assumes: a slot written in the same cycle as a grant treats that grant as
// older than the checkpoint.
module rn_ckpt #(
    parameter int NCKPT = 2,
    parameter int NLOG  = 6,
    parameter int NPHYS = 10,
    localparam int PW   = $clog2(NPHYS),
    localparam int CW   = $clog2(NCKPT)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       take,
    input  logic [CW-1:0]              take_slot,
    input  logic [NLOG-1:0][PW-1:0]    snap_map,
    input  logic                       alloc_en,
    input  logic [NPHYS-1:0]           alloc_mask,
    input  logic [CW-1:0]              rd_slot,
    output logic [NLOG-1:0][PW-1:0]    rd_map,
    output logic [NPHYS-1:0]           rd_since
);
    logic [NCKPT-1:0][NLOG-1:0][PW-1:0] snaps;
    logic [NCKPT-1:0][NPHYS-1:0]        since;

    assign rd_map   = snaps[rd_slot];
    assign rd_since = since[rd_slot];

    for (genvar c = 0; c < NCKPT; c++) begin : g_slot
        // Capture the map into this slot or accumulate grants made after it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int l = 0; l < NLOG; l++) snaps[c][l] <= PW'(l);
                since[c] <= '0;
            end else if (take && take_slot == CW'(c)) begin
                snaps[c] <= snap_map;
                since[c] <= '0;
            end else if (alloc_en) begin
                since[c] <= since[c] | alloc_mask;
            end
        end
    end
endmodule

// File: rtl/rn_rename_top.sv
// Rename stage top: speculative and committed maps, free pool, same-group
// resolution and checkpoint slots.
// Assumes: commits arrive in program order with consistent old/new ids; a
// restore blocks renaming and checkpointing in its cycle.
module rn_rename_top
    import rn_pkg::*;
#(
    parameter int NLOG  = 6,
    parameter int NPHYS = 10,
    parameter int LANES = 2,
    parameter int NCKPT = 2,
    localparam int LW   = $clog2(NLOG),
    localparam int PW   = $clog2(NPHYS),
    localparam int CW   = $clog2(NCKPT)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ren_valid,
    input  logic [LANES-1:0]      ren_lane_vld,
    input  logic [LANES*LW-1:0]   ren_src1,
    input  logic [LANES*LW-1:0]   ren_src2,
    input  logic [LANES*LW-1:0]   ren_dst,
    input  logic [LANES-1:0]      ren_wr,
    output logic                  ren_ready,
    output logic [LANES*PW-1:0]   ren_psrc1,
    output logic [LANES*PW-1:0]   ren_psrc2,
    output logic [LANES*PW-1:0]   ren_pdst,
    output logic [LANES*PW-1:0]   ren_pold,
    input  logic                  cmt_valid,
    input  logic [LW-1:0]         cmt_ldst,
    input  logic [PW-1:0]         cmt_pnew,
    input  logic [PW-1:0]         cmt_pold,
    input  logic                  ck_take,
    input  logic [CW-1:0]         ck_slot,
    input  logic                  rs_valid,
    input  logic                  rs_full,
    input  logic [CW-1:0]         rs_slot
);
    logic [NLOG-1:0][PW-1:0]   spec_q, cmap_q, cmap_next, map_next, ck_map;
    logic [LANES-1:0][PW-1:0]  grant, psrc1_a, psrc2_a, pold_a;
    logic [NPHYS-1:0]          alloc_mask, pool_bits, ck_since, cmap_used;
    logic [LANES-1:0]          lane_wr;
    logic                      fl_enough, fire;
    restore_e                  rs_mode;

    assign lane_wr   = ren_lane_vld & ren_wr;
    assign ren_ready = !rs_valid && fl_enough;
    assign fire      = ren_valid && ren_ready;
    assign ren_psrc1 = psrc1_a;
    assign ren_psrc2 = psrc2_a;
    assign ren_pdst  = grant;
    assign ren_pold  = pold_a;

    // Decode the restore request into its mode.
    always_comb begin
        if (!rs_valid)    rs_mode = RST_NONE;
        else if (rs_full) rs_mode = RST_COMMITTED;
        else              rs_mode = RST_SNAP;
    end

    // Committed map after this cycle's commit, and the registers it occupies.
    always_comb begin
        cmap_next = cmap_q;
        if (cmt_valid) cmap_next[cmt_ldst] = cmt_pnew;
        cmap_used = '0;
        for (int l = 0; l < NLOG; l++) cmap_used[cmap_next[l]] = 1'b1;
    end

    rn_freelist #(.NPHYS(NPHYS), .NLOG(NLOG), .LANES(LANES)) u_free (
        .clk        (clk),
        .rst_n      (rst_n),
        .want       (lane_wr),
        .take_en    (fire),
        .rel_en     (cmt_valid),
        .rel_id     (cmt_pold),
        .merge_en   (rs_mode == RST_SNAP),
        .merge_mask (ck_since),
        .load_en    (rs_mode == RST_COMMITTED),
        .load_mask  (~cmap_used),
        .grant      (grant),
        .alloc_mask (alloc_mask),
        .enough     (fl_enough),
        .pool       (pool_bits)
    );

    rn_resolve #(.NLOG(NLOG), .NPHYS(NPHYS), .LANES(LANES)) u_res (
        .map_cur  (spec_q),
        .lane_wr  (lane_wr),
        .src1     (ren_src1),
        .src2     (ren_src2),
        .dst      (ren_dst),
        .pnew     (grant),
        .psrc1    (psrc1_a),
        .psrc2    (psrc2_a),
        .pold     (pold_a),
        .map_next (map_next)
    );

    rn_ckpt #(.NCKPT(NCKPT), .NLOG(NLOG), .NPHYS(NPHYS)) u_ckpt (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (ck_take && !rs_valid),
        .take_slot  (ck_slot),
        .snap_map   (fire ? map_next : spec_q),
        .alloc_en   (fire),
        .alloc_mask (alloc_mask),
        .rd_slot    (rs_slot),
        .rd_map     (ck_map),
        .rd_since   (ck_since)
    );

    // Speculative map: restore sources first, otherwise the renamed group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < NLOG; l++) spec_q[l] <= PW'(l);
        end else begin
            case (rs_mode)
                RST_COMMITTED: spec_q <= cmap_next;
                RST_SNAP:      spec_q <= ck_map;
                default:       if (fire) spec_q <= map_next;
            endcase
        end
    end

    // Committed map follows the commit port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < NLOG; l++) cmap_q[l] <= PW'(l);
        end else begin
            cmap_q <= cmap_next;
        end
    end
endmodule

// File: rtl/rn_rename_chk.sv
// Property checker for the rename stage, attached by bind.
// Assumes: the environment commits in order with consistent ids.
module rn_rename_chk #(
    parameter int LANES = 2,
    parameter int NLOG  = 6,
    parameter int NPHYS = 10,
    localparam int LW   = $clog2(NLOG),
    localparam int PW   = $clog2(NPHYS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 fire,
    input logic [LANES-1:0]     lane_wr,
    input logic [LANES-1:0]     lane_vld,
    input logic [LANES*LW-1:0]  src1,
    input logic [LANES*LW-1:0]  dst,
    input logic [LANES*PW-1:0]  psrc1,
    input logic [LANES*PW-1:0]  pdst,
    input logic [NPHYS-1:0]     pool,
    input logic                 cmt_valid,
    input logic [PW-1:0]        cmt_pold
);
    // Pool never holds more than the registers beyond the logical set.
    assert_pool_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pool) <= NPHYS - NLOG);

    // A committed previous register is back in the pool one cycle later.
    assert_commit_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_valid |=> pool[$past(cmt_pold)]);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // A grant names a register that is free at the time.
        assert_grant_is_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
            fire && lane_wr[k] |-> pool[pdst[k*PW +: PW]]);

        // A granted register is gone from the pool next cycle.
        assert_grant_consumed_R2: assert property (@(posedge clk) disable iff (!rst_n)
            fire && lane_wr[k] |=> !pool[$past(pdst[k*PW +: PW])]);

        if (k > 0) begin : g_pair
            // Adjacent writers never share a register.
            assert_grant_distinct_R2: assert property (@(posedge clk) disable iff (!rst_n)
                fire && lane_wr[k] && lane_wr[k-1] |->
                pdst[k*PW +: PW] != pdst[(k-1)*PW +: PW]);

            // A source written by the previous lane takes that lane's grant.
            assert_group_steer_R3: assert property (@(posedge clk) disable iff (!rst_n)
                fire && lane_vld[k] && lane_wr[k-1] &&
                src1[k*LW +: LW] == dst[(k-1)*LW +: LW] |->
                psrc1[k*PW +: PW] == pdst[(k-1)*PW +: PW]);
        end
    end
endmodule

bind rn_rename_top rn_rename_chk #(.LANES(LANES), .NLOG(NLOG), .NPHYS(NPHYS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .lane_wr   (lane_wr),
    .lane_vld  (ren_lane_vld),
    .src1      (ren_src1),
    .dst       (ren_dst),
    .psrc1     (ren_psrc1),
    .pdst      (ren_pdst),
    .pool      (pool_bits),
    .cmt_valid (cmt_valid),
    .cmt_pold  (cmt_pold)
);

// File: tb/tb_rn_rename_top.sv
// Directed bench for the rename stage with a reference model of maps and pool.
module tb_rn_rename_top;
    localparam int NL = 6, NP = 10, W = 2, LW = 3, PW = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ren_valid;
    logic [W-1:0] ren_lane_vld, ren_wr;
    logic [W*LW-1:0] ren_src1, ren_src2, ren_dst;
    logic ren_ready;
    logic [W*PW-1:0] ren_psrc1, ren_psrc2, ren_pdst, ren_pold;
    logic cmt_valid;
    logic [LW-1:0] cmt_ldst;
    logic [PW-1:0] cmt_pnew, cmt_pold;
    logic ck_take, rs_valid, rs_full;
    logic [0:0] ck_slot, rs_slot;

    always #10 clk = ~clk;

    rn_rename_top dut (.*);

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    // stimulus
    bit r_valid, k_take, x_valid, x_full, c_valid;
    int k_slot, x_slot, c_l, c_new, c_old;
    bit vld[W], wr[W];
    int s1[W], s2[W], d[W];
    // model
    int m_spec[NL], m_cmap[NL], m_ck[2][NL], ck_tail[2];
    bit m_free[NP], m_since[2][NP];
    int q_l[64], q_n[64], q_o[64], qh = 0, qt = 0;
    // last observed
    bit obs_ready;
    int obs_pdst[W], obs_psrc1[W], obs_pold[W];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_stim();
        r_valid = 0; k_take = 0; x_valid = 0; x_full = 0; c_valid = 0;
        k_slot = 0; x_slot = 0; c_l = 0; c_new = 0; c_old = 0;
        for (int k = 0; k < W; k++) begin vld[k] = 0; wr[k] = 0; s1[k] = 0; s2[k] = 0; d[k] = 0; end
    endtask

    task automatic step(input string req);
        int need, nfree, ps1, ps2, po;
        int al[W];
        bit er, fire, hit;
        bit tmpf[NP];
        @(negedge clk);
        ren_valid = r_valid; cmt_valid = c_valid; cmt_ldst = LW'(c_l);
        cmt_pnew = PW'(c_new); cmt_pold = PW'(c_old);
        ck_take = k_take; ck_slot = 1'(k_slot);
        rs_valid = x_valid; rs_full = x_full; rs_slot = 1'(x_slot);
        for (int k = 0; k < W; k++) begin
            ren_lane_vld[k] = vld[k]; ren_wr[k] = wr[k];
            ren_src1[k*LW +: LW] = LW'(s1[k]);
            ren_src2[k*LW +: LW] = LW'(s2[k]);
            ren_dst[k*LW +: LW]  = LW'(d[k]);
        end
        #1;
        need = 0; nfree = 0;
        for (int k = 0; k < W; k++) if (vld[k] && wr[k]) need++;
        for (int p = 0; p < NP; p++) if (m_free[p]) nfree++;
        er = !x_valid && (nfree >= need);
        obs_ready = ren_ready;
        chk(ren_ready === er, req, "ready", int'(ren_ready), int'(er));
        fire = r_valid && er;
        tmpf = m_free;
        for (int k = 0; k < W; k++) begin
            al[k] = -1; hit = 0;
            if (vld[k] && wr[k])
                for (int p = 0; p < NP; p++)
                    if (!hit && tmpf[p]) begin al[k] = p; tmpf[p] = 0; hit = 1; end
        end
        if (fire) begin
            for (int k = 0; k < W; k++) begin
                if (!vld[k]) continue;
                ps1 = m_spec[s1[k]]; ps2 = m_spec[s2[k]]; po = m_spec[d[k]];
                for (int i = 0; i < k; i++) if (vld[i] && wr[i]) begin
                    if (d[i] == s1[k]) ps1 = al[i];
                    if (d[i] == s2[k]) ps2 = al[i];
                    if (d[i] == d[k])  po  = al[i];
                end
                obs_psrc1[k] = int'(ren_psrc1[k*PW +: PW]);
                obs_pdst[k]  = int'(ren_pdst[k*PW +: PW]);
                obs_pold[k]  = int'(ren_pold[k*PW +: PW]);
                chk(obs_psrc1[k] == ps1, req, "psrc1", obs_psrc1[k], ps1);
                chk(int'(ren_psrc2[k*PW +: PW]) == ps2, req, "psrc2",
                    int'(ren_psrc2[k*PW +: PW]), ps2);
                if (wr[k]) begin
                    chk(obs_pdst[k] == al[k], req, "pdst", obs_pdst[k], al[k]);
                    chk(obs_pold[k] == po, req, "pold", obs_pold[k], po);
                end
            end
        end
        @(posedge clk);
        if (c_valid) begin m_cmap[c_l] = c_new; m_free[c_old] = 1; end
        if (x_valid) begin
            if (x_full) begin
                for (int p = 0; p < NP; p++) m_free[p] = 1;
                for (int l = 0; l < NL; l++) begin m_spec[l] = m_cmap[l]; m_free[m_cmap[l]] = 0; end
                qt = qh;
            end else begin
                for (int l = 0; l < NL; l++) m_spec[l] = m_ck[x_slot][l];
                for (int p = 0; p < NP; p++) if (m_since[x_slot][p]) m_free[p] = 1;
                qt = ck_tail[x_slot];
            end
        end else begin
            if (fire)
                for (int k = 0; k < W; k++) if (vld[k] && wr[k]) begin
                    q_l[qt % 64] = d[k]; q_n[qt % 64] = al[k]; q_o[qt % 64] = m_spec[d[k]];
                    qt++;
                    m_spec[d[k]] = al[k];
                    m_free[al[k]] = 0;
                    for (int c = 0; c < 2; c++) m_since[c][al[k]] = 1;
                end
            if (k_take) begin
                for (int l = 0; l < NL; l++) m_ck[k_slot][l] = m_spec[l];
                for (int p = 0; p < NP; p++) m_since[k_slot][p] = 0;
                ck_tail[k_slot] = qt;
            end
        end
        clear_stim();
    endtask

    // Read every logical register through sources without writing.
    task automatic probe(input string req);
        for (int b = 0; b < NL; b += 4) begin
            r_valid = 1;
            for (int k = 0; k < W; k++) begin
                vld[k] = 1; s1[k] = (b + 2*k) % NL; s2[k] = (b + 2*k + 1) % NL;
            end
            step(req);
        end
    endtask

    task automatic ren1(input int dd);
        r_valid = 1; vld[0] = 1; wr[0] = 1; d[0] = dd; s1[0] = dd; s2[0] = 0;
    endtask

    task automatic ren2(input int d0, input int d1);
        r_valid = 1;
        vld[0] = 1; wr[0] = 1; d[0] = d0; s1[0] = 1; s2[0] = 2;
        vld[1] = 1; wr[1] = 1; d[1] = d1; s1[1] = 3; s2[1] = 5;
    endtask

    task automatic commit_one(input string req);
        c_valid = 1; c_l = q_l[qh % 64]; c_new = q_n[qh % 64]; c_old = q_o[qh % 64];
        qh++;
        step(req);
    endtask

    task automatic t_reset();
        probe("R1");
        ren1(1); step("R1");
        chk(obs_pdst[0] == NL, "R1", "first grant", obs_pdst[0], NL);
    endtask

    task automatic t_alloc();
        ren2(2, 3); step("R2");
        chk(obs_pdst[0] == 7, "R2", "lane0 grant", obs_pdst[0], 7);
        chk(obs_pdst[1] == 8, "R2", "lane1 grant", obs_pdst[1], 8);
    endtask

    task automatic t_stall();
        ren2(4, 0); step("R5");
        chk(obs_ready == 0, "R5", "ready with one free", int'(obs_ready), 0);
        probe("R5");
        ren1(5); step("R5");
        chk(obs_pdst[0] == 9, "R5", "last free grant", obs_pdst[0], 9);
        ren1(0); step("R5");
        chk(obs_ready == 0, "R5", "ready with empty pool", int'(obs_ready), 0);
    endtask

    task automatic t_nowrite();
        r_valid = 1;
        for (int k = 0; k < W; k++) begin vld[k] = 1; wr[k] = 0; d[k] = k; s1[k] = k; s2[k] = 4; end
        step("R10");
        chk(obs_ready == 1, "R10", "ready without writers", int'(obs_ready), 1);
        probe("R10");
    endtask

    task automatic t_commit();
        while (qh != qt) commit_one("R6");
        ren1(0); step("R6");
        chk(obs_pdst[0] == 1, "R6", "freed register regranted", obs_pdst[0], 1);
    endtask

    task automatic t_group();
        r_valid = 1;
        vld[0] = 1; wr[0] = 1; s1[0] = 2; s2[0] = 3; d[0] = 4;
        vld[1] = 1; wr[1] = 1; s1[1] = 4; s2[1] = 4; d[1] = 4;
        step("R3");
        chk(obs_psrc1[1] == obs_pdst[0], "R3", "steered source", obs_psrc1[1], obs_pdst[0]);
        chk(obs_pold[1] == obs_pdst[0], "R4", "steered previous", obs_pold[1], obs_pdst[0]);
        chk(obs_pold[0] == 4, "R4", "lane0 previous", obs_pold[0], 4);
        probe("R4");
    endtask

    task automatic t_ckpt();
        int first_after;
        while (qh != qt) commit_one("R6");
        ren1(1); k_take = 1; k_slot = 0; step("R7");
        ren2(2, 1); step("R8");
        first_after = obs_pdst[0];
        ren1(3); x_valid = 1; x_slot = 0; step("R8");
        chk(obs_ready == 0, "R8", "ready during restore", int'(obs_ready), 0);
        probe("R7");
        ren1(3); step("R8");
        chk(obs_pdst[0] == first_after, "R8", "returned register", obs_pdst[0], first_after);
    endtask

    task automatic t_flush();
        commit_one("R9");
        ren2(5, 2); step("R9");
        x_valid = 1; x_full = 1; step("R9");
        probe("R9");
        ren2(0, 4); step("R9");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog all-requirements actual=timeout expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        clear_stim();
        ren_valid = 0; ren_lane_vld = '0; ren_wr = '0; ren_src1 = '0; ren_src2 = '0; ren_dst = '0;
        cmt_valid = 0; cmt_ldst = '0; cmt_pnew = '0; cmt_pold = '0;
        ck_take = 0; ck_slot = '0; rs_valid = 0; rs_full = 0; rs_slot = '0;
        for (int l = 0; l < NL; l++) begin
            m_spec[l] = l; m_cmap[l] = l; m_ck[0][l] = l; m_ck[1][l] = l;
        end
        for (int p = 0; p < NP; p++) begin
            m_free[p] = (p >= NL); m_since[0][p] = 0; m_since[1][p] = 0;
        end
        ck_tail[0] = 0; ck_tail[1] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_alloc();
        t_stall();
        t_nowrite();
        t_commit();
        t_group();
        t_ckpt();
        t_flush();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule